// File: doc/BRIEF.md
# Disk Host Bus Interface

This block is the device-side logic behind an asynchronous parallel disk-drive host bus. The host drives two active-low chip selects, a 3-bit register address and active-low read and write strobes. All of these pass through a two-flop synchronizer into the core clock. The block finds strobe edges on the synchronized copies and decodes each access. One chip select reaches the command register block. Within that block, address 0 is the 16-bit data port. The other chip select reaches the control register block. The bidirectional data bus is split into an input, an output and an output enable, which a pad ring joins.

Register contents live in a small internal register file. The data port is backed by two FIFOs. The transmit FIFO is filled by the device side and drained by host reads. The receive FIFO is filled by host writes and drained by the device side. When the FIFO behind a data-port access cannot serve it, the block pulls the ready line low to stretch the host cycle. The ready line is modelled as a drive-low enable.

When the command engine enables DMA, the block runs a request/acknowledge handshake. Chip selects are ignored in this mode, every transfer is 16 bits, and the strobe that is active picks the direction.

Top module: `disk_host_if`

## Requirements
- R1: While reset is held and right after it, dd_oe, dmarq, rdy_hold and wide16 are 0, dev_rx_empty is 1 and dev_tx_full is 0.
- R2: In PIO mode, addresses 1 to 7 with only cs_cmd_n low reach seven command registers. Addresses 0 to 7 with only cs_ctl_n low reach eight control registers. These fifteen registers are separate storage. Address 0 with only cs_cmd_n low is the data port.
- R3: A register write stores dd_i[7:0] when the synchronized write strobe rises. A register read returns the stored byte on dd_o[7:0], with dd_o[15:8] equal to 0.
- R4: dd_o is loaded when the synchronized read strobe falls and keeps that value after the strobe ends. dd_oe is 1 exactly when the synchronized read strobe (two clocks late) is low and the access targets the device. An access targets the device when exactly one chip select is low in PIO mode, or when dmack_n is low in DMA mode.
- R5: wide16 is 1 exactly when the synchronized inputs address the data port in PIO mode (cs_cmd_n low, cs_ctl_n high, address 0). It is never 1 while dma_en is 1.
- R6: A PIO data-port write pushes all 16 bits of dd_i into the receive FIFO. A PIO data-port read pops the transmit FIFO. Both keep first-in first-out order.
- R7: A data-port read that finds the transmit FIFO empty sets rdy_hold. Once the device pushes a word, that word is loaded into dd_o and rdy_hold is released.
- R8: While a data-port write strobe is low and the receive FIFO is full, rdy_hold is 1. It drops in the clock after the device pops a word.
- R9: With dma_en set, dmarq rises when the FIFO for the current direction can serve: the transmit FIFO is not empty for dma_to_host=1, and the receive FIFO is not full for dma_to_host=0. dmarq stays high until the synchronized dmack_n is seen low, then drops. After dmack_n is released, dmarq rises again only if more data can move.
- R10: With dma_en set and dmack_n low, a read strobe pops a 16-bit word from the transmit FIFO and a write strobe pushes a 16-bit word into the receive FIFO.
- R11: While dma_en is 1, accesses made with chip selects are ignored: registers keep their values, no FIFO word moves and dd_oe stays 0.
- R12: A host push and a device pop of the same FIFO in the same clock are both performed, keeping order and the word count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_cmd_n | input | 1 | Active-low command block select |
| cs_ctl_n | input | 1 | Active-low control block select |
| reg_addr | input | 3 | Register address within the selected block |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| dmack_n | input | 1 | Active-low DMA acknowledge |
| dd_i | input | 16 | Data bus, host to device |
| dd_o | output | 16 | Data bus, device to host |
| dd_oe | output | 1 | Data bus output enable |
| wide16 | output | 1 | 16-bit data port width indication |
| dmarq | output | 1 | DMA request |
| rdy_hold | output | 1 | Pull the ready line low (cycle stretch) |
| dma_en | input | 1 | DMA mode enable from the command engine |
| dma_to_host | input | 1 | DMA direction expected by the command engine |
| dev_tx_push | input | 1 | Device pushes a word for the host |
| dev_tx_data | input | 16 | Word pushed by the device |
| dev_tx_full | output | 1 | Transmit FIFO full |
| dev_rx_pop | input | 1 | Device pops a word written by the host |
| dev_rx_data | output | 16 | Head of the receive FIFO |
| dev_rx_empty | output | 1 | Receive FIFO empty |

## Verification
The two functions that share a clock are the host side and the device side of the same FIFO. The bench times a device pop of the receive FIFO to land on the exact clock where the synchronized write strobe rises. It then judges the result by draining the FIFO and comparing order and count with its own queue. A second overlap occurs while a stalled data-port read is waiting. There, the device push and the fetch that releases the ready line follow in consecutive clocks. The check is that the stretch ends with the pushed word already on dd_o.

// File: rtl/dhi_pkg.sv
`timescale 1ns/1ps
package dhi_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_CMD_REG,
    ACC_CTL_REG,
    ACC_PIO_PORT,
    ACC_DMA_PORT
  } acc_e;

  typedef enum logic [1:0] {
    DQ_IDLE,
    DQ_REQ,
    DQ_XFER
  } dq_state_e;

  // Classify one synchronized bus state. All selects are active high here.
  function automatic acc_e classify(input logic cmd_sel, input logic ctl_sel,
                                    input logic ack, input logic dma_mode,
                                    input logic addr_zero);
    acc_e k;
    if (dma_mode)
      k = ack ? ACC_DMA_PORT : ACC_NONE;
    else if (cmd_sel && !ctl_sel)
      k = addr_zero ? ACC_PIO_PORT : ACC_CMD_REG;
    else if (ctl_sel && !cmd_sel)
      k = ACC_CTL_REG;
    else
      k = ACC_NONE;
    return k;
  endfunction

  function automatic logic is_reg(input acc_e k);
    return (k == ACC_CMD_REG) || (k == ACC_CTL_REG);
  endfunction

  function automatic logic is_port(input acc_e k);
    return (k == ACC_PIO_PORT) || (k == ACC_DMA_PORT);
  endfunction

endpackage

// File: rtl/dhi_sync.sv
`timescale 1ns/1ps
module dhi_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dhi_fifo.sv
`timescale 1ns/1ps
module dhi_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= next_ptr(wp);
      if (do_pop)  rp <= next_ptr(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/dhi_regfile.sv
`timescale 1ns/1ps
module dhi_regfile #(
  parameter int W  = 8,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdata
);
  localparam int N = 1 << IW;

  logic [W-1:0] regs [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we) begin
      regs[widx] <= wdata;
    end
  end

  assign rdata = regs[ridx];
endmodule

// File: rtl/dhi_dma.sv
`timescale 1ns/1ps
module dhi_dma
  import dhi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dma_en,
  input  logic can_serve,
  input  logic ack,
  output logic req
);
  dq_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= DQ_IDLE;
    end else begin
      unique case (st)
        DQ_IDLE: if (dma_en && can_serve) st <= DQ_REQ;
        DQ_REQ: begin
          if (!dma_en)  st <= DQ_IDLE;
          else if (ack) st <= DQ_XFER;
        end
        DQ_XFER: if (!ack) st <= DQ_IDLE;
        default: st <= DQ_IDLE;
      endcase
    end
  end

  assign req = (st == DQ_REQ);
endmodule

// File: rtl/disk_host_if.sv
`timescale 1ns/1ps
module disk_host_if
  import dhi_pkg::*;
#(
  parameter int DW         = 16,
  parameter int AW         = 3,
  parameter int RW         = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_cmd_n,
  input  logic          cs_ctl_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          dmack_n,
  input  logic [DW-1:0] dd_i,
  output logic [DW-1:0] dd_o,
  output logic          dd_oe,
  output logic          wide16,
  output logic          dmarq,
  output logic          rdy_hold,
  input  logic          dma_en,
  input  logic          dma_to_host,
  input  logic          dev_tx_push,
  input  logic [DW-1:0] dev_tx_data,
  output logic          dev_tx_full,
  input  logic          dev_rx_pop,
  output logic [DW-1:0] dev_rx_data,
  output logic          dev_rx_empty
);
  localparam int IW = AW + 1;
  localparam int SW = AW + 5;
  localparam logic [SW-1:0] SYNC_IDLE = {5'b11111, {AW{1'b0}}};

  // Synchronized host bus
  logic [SW-1:0] raw_bus, sync_bus;
  logic          cmd_sn, ctl_sn, ack_sn, rd_sn, wr_sn;
  logic [AW-1:0] addr_s;
  logic          ack_s;

  assign raw_bus = {cs_cmd_n, cs_ctl_n, dmack_n, rd_n, wr_n, reg_addr};

  dhi_sync #(.W(SW), .RST_VAL(SYNC_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
  );

  assign cmd_sn = sync_bus[SW-1];
  assign ctl_sn = sync_bus[SW-2];
  assign ack_sn = sync_bus[SW-3];
  assign rd_sn  = sync_bus[SW-4];
  assign wr_sn  = sync_bus[SW-5];
  assign addr_s = sync_bus[AW-1:0];
  assign ack_s  = ~ack_sn;

  // Strobe edge events
  logic rd_q, wr_q, rd_fall, wr_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b1;
      wr_q <= 1'b1;
    end else begin
      rd_q <= rd_sn;
      wr_q <= wr_sn;
    end
  end

  assign rd_fall = rd_q & ~rd_sn;
  assign wr_rise = ~wr_q & wr_sn;

  // Access decode
  acc_e          kind;
  logic [IW-1:0] reg_idx;
  logic          reg_we, reg_rd, port_rd, rx_push;

  assign kind    = classify(~cmd_sn, ~ctl_sn, ack_s, dma_en, addr_s == '0);
  assign reg_idx = {kind == ACC_CTL_REG, addr_s};
  assign reg_we  = wr_rise & is_reg(kind);
  assign reg_rd  = rd_fall & is_reg(kind);
  assign port_rd = rd_fall & is_port(kind);
  assign rx_push = wr_rise & is_port(kind);

  // Register file
  logic [RW-1:0] reg_rdata;

  dhi_regfile #(.W(RW), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(reg_we), .widx(reg_idx), .wdata(dd_i[RW-1:0]),
    .ridx(reg_idx), .rdata(reg_rdata)
  );

  // Data port FIFOs
  logic [DW-1:0] tx_head;
  logic          tx_empty, tx_pop, rx_full;
  logic          rd_wait_q;

  dhi_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .push(dev_tx_push), .wdata(dev_tx_data),
    .pop(tx_pop), .rdata(tx_head),
    .empty(tx_empty), .full(dev_tx_full)
  );

  dhi_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .wdata(dd_i),
    .pop(dev_rx_pop), .rdata(dev_rx_data),
    .empty(dev_rx_empty), .full(rx_full)
  );

  // Read fetch: immediate, or deferred while the transmit FIFO is empty
  logic [DW-1:0] dd_q;

  assign tx_pop = (port_rd | (rd_wait_q & ~rd_sn)) & ~tx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dd_q      <= '0;
      rd_wait_q <= 1'b0;
    end else begin
      if (reg_rd) dd_q <= {{(DW-RW){1'b0}}, reg_rdata};
      if (tx_pop) dd_q <= tx_head;
      if (port_rd & tx_empty)  rd_wait_q <= 1'b1;
      else if (tx_pop | rd_sn) rd_wait_q <= 1'b0;
    end
  end

  // DMA handshake
  logic can_serve;

  assign can_serve = dma_to_host ? ~tx_empty : ~rx_full;

  dhi_dma u_dma (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en),
    .can_serve(can_serve), .ack(ack_s), .req(dmarq)
  );

  // Bus-facing outputs
  assign dd_o     = dd_q;
  assign dd_oe    = ~rd_sn & (kind != ACC_NONE);
  assign wide16   = (kind == ACC_PIO_PORT);
  assign rdy_hold = rd_wait_q | (~wr_sn & is_port(kind) & rx_full);

endmodule

// File: rtl/dhi_checker.sv
`timescale 1ns/1ps
module dhi_checker (
  input logic clk,
  input logic rst_n,
  input logic rd_n,
  input logic dd_oe,
  input logic dma_en,
  input logic wide16,
  input logic dmarq,
  input logic rdy_hold,
  input logic ack_s,
  input logic wr_sn,
  input logic tx_empty,
  input logic rx_push,
  input logic rx_full,
  input logic dev_rx_pop
);
  p_oe_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dd_oe |-> !$past(rd_n, 2));

  p_no_wide_dma_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_en |-> !wide16);

  p_rdy_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_hold && wr_sn && !tx_empty) |=> !rdy_hold);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |-> dev_rx_pop);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dmarq && !ack_s && dma_en) |=> dmarq);

  p_req_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dmarq && ack_s) |=> !dmarq);

  p_req_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dmarq |-> $past(dma_en));
endmodule

bind disk_host_if dhi_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .dd_oe(dd_oe),
  .dma_en(dma_en), .wide16(wide16), .dmarq(dmarq), .rdy_hold(rdy_hold),
  .ack_s(ack_s), .wr_sn(wr_sn), .tx_empty(tx_empty),
  .rx_push(rx_push), .rx_full(rx_full), .dev_rx_pop(dev_rx_pop)
);

// File: tb/tb_disk_host_if.sv
`timescale 1ns/1ps
module tb_disk_host_if;
  localparam int FD = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_cmd_n, cs_ctl_n, rd_n, wr_n, dmack_n;
  logic [2:0]  reg_addr;
  logic [15:0] dd_i, dd_o, dev_tx_data, dev_rx_data;
  logic        dd_oe, wide16, dmarq, rdy_hold;
  logic        dma_en, dma_to_host, dev_tx_push, dev_tx_full, dev_rx_pop, dev_rx_empty;

  always #2.5 clk = ~clk;

  disk_host_if #(.FIFO_DEPTH(FD)) dut (
    .clk(clk), .rst_n(rst_n), .cs_cmd_n(cs_cmd_n), .cs_ctl_n(cs_ctl_n),
    .reg_addr(reg_addr), .rd_n(rd_n), .wr_n(wr_n), .dmack_n(dmack_n),
    .dd_i(dd_i), .dd_o(dd_o), .dd_oe(dd_oe), .wide16(wide16), .dmarq(dmarq),
    .rdy_hold(rdy_hold), .dma_en(dma_en), .dma_to_host(dma_to_host),
    .dev_tx_push(dev_tx_push), .dev_tx_data(dev_tx_data), .dev_tx_full(dev_tx_full),
    .dev_rx_pop(dev_rx_pop), .dev_rx_data(dev_rx_data), .dev_rx_empty(dev_rx_empty)
  );

  int nchk = 0;
  int nerr = 0;
  logic [7:0]  regm [16];
  logic [15:0] txq [$];
  logic [15:0] rxq [$];
  bit mon_on = 0;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  // Per-clock reference: outputs follow the host pins seen one sample earlier.
  bit p_cmd_n = 1, p_ctl_n = 1, p_ack_n = 1, p_rd_n = 1;
  logic [2:0] p_addr = 3'd0;

  function automatic bit m_targets(bit c_n, bit t_n, bit a_n, bit den);
    if (den) return !a_n;
    return (c_n != t_n);
  endfunction

  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      chk(wide16 == (!dma_en && !p_cmd_n && p_ctl_n && p_addr == 3'd0), "R5 wide16 per clock",
          {15'd0, wide16}, {15'd0, !dma_en && !p_cmd_n && p_ctl_n && p_addr == 3'd0});
      chk(dd_oe == (!p_rd_n && m_targets(p_cmd_n, p_ctl_n, p_ack_n, dma_en)), "R4 dd_oe per clock",
          {15'd0, dd_oe}, {15'd0, !p_rd_n && m_targets(p_cmd_n, p_ctl_n, p_ack_n, dma_en)});
    end
    p_cmd_n = cs_cmd_n; p_ctl_n = cs_ctl_n; p_ack_n = dmack_n; p_rd_n = rd_n; p_addr = reg_addr;
  end

  initial begin
    #750000;
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_bus();
    @(negedge clk);
    cs_cmd_n = 1; cs_ctl_n = 1; reg_addr = 0; rd_n = 1; wr_n = 1; dmack_n = 1;
  endtask

  task automatic pio_write(input bit c_n, input bit t_n, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cs_cmd_n = c_n; cs_ctl_n = t_n; reg_addr = a; dd_i = d;
    clocks(2);
    wr_n = 0;
    clocks(4);
    for (int k = 0; k < 100 && rdy_hold; k++) @(negedge clk);
    wr_n = 1;
    clocks(4);
    idle_bus();
    if (!dma_en) begin
      if (!c_n && t_n) begin
        if (a == 0) rxq.push_back(d);
        else regm[{1'b0, a}] = d[7:0];
      end else if (c_n && !t_n) regm[{1'b1, a}] = d[7:0];
    end
  endtask

  task automatic pio_read(input bit c_n, input bit t_n, input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    cs_cmd_n = c_n; cs_ctl_n = t_n; reg_addr = a;
    clocks(2);
    rd_n = 0;
    clocks(4);
    for (int k = 0; k < 100 && rdy_hold; k++) @(negedge clk);
    clocks(2);
    chk(dd_oe == 1'b1, "R4 dd_oe during read", {15'd0, dd_oe}, 16'd1);
    d = dd_o;
    rd_n = 1;
    clocks(4);
    idle_bus();
  endtask

  task automatic dev_push(input logic [15:0] d);
    @(negedge clk);
    dev_tx_push = 1; dev_tx_data = d;
    txq.push_back(d);
    @(negedge clk);
    dev_tx_push = 0;
  endtask

  task automatic dev_pop(input string req);
    logic [15:0] e;
    @(negedge clk);
    e = rxq.pop_front();
    chk(!dev_rx_empty, req, {15'd0, !dev_rx_empty}, 16'd1);
    chk(dev_rx_data == e, req, dev_rx_data, e);
    dev_rx_pop = 1;
    @(negedge clk);
    dev_rx_pop = 0;
  endtask

  task automatic dma_read(output logic [15:0] d);
    int w = 0;
    while (!dmarq && w < 30) begin @(negedge clk); w++; end
    chk(dmarq == 1'b1, "R9 dmarq raised for data to host", {15'd0, dmarq}, 16'd1);
    dmack_n = 0;
    clocks(1);
    chk(dmarq == 1'b1, "R9 dmarq held before ack seen", {15'd0, dmarq}, 16'd1);
    clocks(3);
    chk(dmarq == 1'b0, "R9 dmarq dropped after ack", {15'd0, dmarq}, 16'd0);
    chk(wide16 == 1'b0, "R5 no wide16 in DMA", {15'd0, wide16}, 16'd0);
    rd_n = 0;
    clocks(4);
    d = dd_o;
    rd_n = 1;
    clocks(3);
    dmack_n = 1;
    clocks(3);
  endtask

  task automatic dma_write(input logic [15:0] d);
    int w = 0;
    while (!dmarq && w < 30) begin @(negedge clk); w++; end
    chk(dmarq == 1'b1, "R9 dmarq raised for data from host", {15'd0, dmarq}, 16'd1);
    dmack_n = 0; dd_i = d;
    clocks(4);
    chk(dmarq == 1'b0, "R9 dmarq dropped after ack", {15'd0, dmarq}, 16'd0);
    wr_n = 0;
    clocks(4);
    wr_n = 1;
    clocks(3);
    dmack_n = 1;
    clocks(3);
    rxq.push_back(d);
  endtask

  initial begin
    logic [15:0] r, e;
    rst_n = 0;
    cs_cmd_n = 1; cs_ctl_n = 1; reg_addr = 0; rd_n = 1; wr_n = 1; dmack_n = 1;
    dd_i = 0; dma_en = 0; dma_to_host = 1; dev_tx_push = 0; dev_tx_data = 0; dev_rx_pop = 0;
    for (int i = 0; i < 16; i++) regm[i] = 8'h00;
    clocks(4);
    chk(dd_oe == 0 && dmarq == 0 && rdy_hold == 0 && wide16 == 0, "R1 outputs in reset",
        {12'd0, dd_oe, dmarq, rdy_hold, wide16}, 16'd0);
    chk(dev_rx_empty == 1 && dev_tx_full == 0, "R1 FIFO flags in reset",
        {14'd0, dev_rx_empty, dev_tx_full}, 16'b10);
    rst_n = 1;
    clocks(3);
    chk(dd_oe == 0 && dmarq == 0 && rdy_hold == 0 && wide16 == 0, "R1 outputs after reset",
        {12'd0, dd_oe, dmarq, rdy_hold, wide16}, 16'd0);
    mon_on = 1;

    // R2 / R3: both register blocks, upper byte of writes discarded
    for (int a = 1; a < 8; a++) pio_write(0, 1, 3'(a), {8'hA5, 8'h10 + 8'(a)});
    for (int a = 0; a < 8; a++) pio_write(1, 0, 3'(a), {8'h5A, 8'h80 + 8'(a)});
    for (int a = 1; a < 8; a++) begin
      pio_read(0, 1, 3'(a), r);
      e = {8'h00, regm[{1'b0, 3'(a)}]};
      chk(r == e, "R2 R3 command register read", r, e);
    end
    for (int a = 0; a < 8; a++) begin
      pio_read(1, 0, 3'(a), r);
      e = {8'h00, regm[{1'b1, 3'(a)}]};
      chk(r == e, "R2 R3 control register read", r, e);
    end
    clocks(2);
    chk(dd_o == e && dd_oe == 0, "R4 dd_o held after strobe", dd_o, e);

    // R5: width indication follows the decode
    @(negedge clk); cs_cmd_n = 0; reg_addr = 0;
    clocks(3);
    chk(wide16 == 1, "R5 data port wide", {15'd0, wide16}, 16'd1);
    reg_addr = 3;
    clocks(3);
    chk(wide16 == 0, "R5 register narrow", {15'd0, wide16}, 16'd0);
    idle_bus();

    // R6: PIO data port both directions
    dev_push(16'h1234); dev_push(16'hABCD); dev_push(16'h0F0F);
    for (int i = 0; i < 3; i++) begin
      pio_read(0, 1, 3'd0, r);
      e = txq.pop_front();
      chk(r == e, "R6 data port read order", r, e);
    end
    pio_write(0, 1, 3'd0, 16'hBEEF);
    pio_write(0, 1, 3'd0, 16'hCAFE);
    dev_pop("R6 data port write order");
    dev_pop("R6 data port write order");

    // R7: read stalls on empty transmit FIFO
    @(negedge clk); cs_cmd_n = 0; reg_addr = 0;
    clocks(2);
    rd_n = 0;
    clocks(5);
    chk(rdy_hold == 1, "R7 stretch on empty", {15'd0, rdy_hold}, 16'd1);
    dev_push(16'hC0DE);
    clocks(2);
    e = txq.pop_front();
    chk(rdy_hold == 0, "R7 stretch released", {15'd0, rdy_hold}, 16'd0);
    chk(dd_o == e, "R7 pushed word delivered", dd_o, e);
    rd_n = 1;
    clocks(4);
    idle_bus();

    // R8: write stalls on full receive FIFO
    for (int i = 0; i < FD; i++) pio_write(0, 1, 3'd0, 16'hB000 + 16'(i));
    @(negedge clk); cs_cmd_n = 0; reg_addr = 0; dd_i = 16'hB0FF;
    clocks(2);
    wr_n = 0;
    clocks(4);
    chk(rdy_hold == 1, "R8 stretch on full", {15'd0, rdy_hold}, 16'd1);
    dev_pop("R8 pop while stretched");
    clocks(1);
    chk(rdy_hold == 0, "R8 stretch released", {15'd0, rdy_hold}, 16'd0);
    wr_n = 1;
    rxq.push_back(16'hB0FF);
    clocks(4);
    idle_bus();
    for (int i = 0; i < FD; i++) dev_pop("R8 drain order");
    chk(dev_rx_empty == 1, "R8 drained", {15'd0, dev_rx_empty}, 16'd1);

    // R12: host push and device pop in the same clock
    pio_write(0, 1, 3'd0, 16'h1111);
    @(negedge clk); cs_cmd_n = 0; reg_addr = 0; dd_i = 16'h2222;
    clocks(2);
    wr_n = 0;
    clocks(4);
    wr_n = 1;
    clocks(2);
    e = rxq.pop_front();
    chk(dev_rx_data == e, "R12 head before overlap", dev_rx_data, e);
    dev_rx_pop = 1;
    @(negedge clk);
    dev_rx_pop = 0;
    rxq.push_back(16'h2222);
    clocks(3);
    idle_bus();
    dev_pop("R12 overlap kept word");
    chk(dev_rx_empty == 1, "R12 count after overlap", {15'd0, dev_rx_empty}, 16'd1);

    // R9 / R10: DMA to host
    dev_push(16'hD001); dev_push(16'hD002);
    @(negedge clk); dma_to_host = 1; dma_en = 1;
    for (int i = 0; i < 2; i++) begin
      dma_read(r);
      e = txq.pop_front();
      chk(r == e, "R10 DMA read word", r, e);
    end
    clocks(10);
    chk(dmarq == 0, "R9 no request without data", {15'd0, dmarq}, 16'd0);
    @(negedge clk); dma_en = 0;

    // R9 / R10: DMA from host
    @(negedge clk); dma_to_host = 0; dma_en = 1;
    dma_write(16'hE001);
    dma_write(16'hE002);
    @(negedge clk); dma_en = 0;
    clocks(3);
    dev_pop("R10 DMA write word");
    dev_pop("R10 DMA write word");

    // R11: chip-select accesses ignored in DMA mode
    dev_push(16'h7777);
    @(negedge clk); dma_to_host = 1; dma_en = 1;
    pio_write(0, 1, 3'd5, 16'h003C);
    @(negedge clk); cs_cmd_n = 0; reg_addr = 0;
    clocks(2);
    rd_n = 0;
    clocks(5);
    chk(dd_oe == 0, "R11 no drive in DMA mode", {15'd0, dd_oe}, 16'd0);
    chk(wide16 == 0, "R11 no width in DMA mode", {15'd0, wide16}, 16'd0);
    rd_n = 1;
    clocks(4);
    idle_bus();
    @(negedge clk); dma_en = 0;
    clocks(4);
    pio_read(0, 1, 3'd5, r);
    e = {8'h00, regm[5]};
    chk(r == e, "R11 register unchanged", r, e);
    pio_read(0, 1, 3'd0, r);
    e = txq.pop_front();
    chk(r == e, "R11 transmit word not consumed", r, e);

    clocks(5);
    finish_run();
  end
endmodule